// File: doc/BRIEF.md
# Peripheral Clock-Stop and Reset Control Registers

This block is the part of a system controller that holds the reset lines and the clock-stop controls for up to 64 peripherals. The 64 reset lines sit in two 32-bit words, and the 64 clock-stop controls sit in two more. A peripheral with index i uses bit (i mod 32) of the lower word when i is below 32, and of the upper word otherwise. Each of these words is changed by two write addresses. A write to the base address turns on every bit that is 1 in the data. A write to the base address plus 4 turns off every bit that is 1 in the data. Software can therefore change one peripheral without a read-modify-write.

The block decodes each word into per-peripheral outputs. `periph_rst` is high while a peripheral is held in reset. `periph_clk_en` is high while its clock runs. For most clock bits a stored 1 stops the clock. One bit, lower-word bit 14, has the opposite sense: a stored 1 runs its clock. Lower-word bit 31 is not a clock gate. It selects the divide-by-13 reference for the second UART group. A separate miscellaneous word holds the divide-by-13 select for the first UART group.

Requests arrive on a simple valid/ready bus that accepts one request per cycle. Read data returns one cycle after the read is accepted.

Top module: `scr_clkrst_regs`

## Requirements
- R1: After reset, both reset words read 0xFFFFFFFF and the upper clock-stop word reads 0xFFFFFFFF. The lower clock-stop word reads 0x7FFFBFFF and the miscellaneous word reads 0. So `periph_rst` is all ones, `periph_clk_en` is all zeros, and both UART divide selects are 0.
- R2: A write to a base address (reset words 0x040/0x050, clock-stop words 0x080/0x090) sets every bit that is 1 in the data and leaves the other bits unchanged.
- R3: A write to base+4 (0x044/0x054/0x084/0x094) clears every bit that is 1 in the data and leaves the other bits unchanged.
- R4: `periph_rst[i]` equals bit i of word 0x040 for i<32, and bit i-32 of word 0x050 for i>=32. A 1 holds the peripheral in reset.
- R5: `periph_clk_en[i]` is the inverse of its clock-stop bit (word 0x080 for i<32, 0x090 for i>=32). The exceptions are index 14, where it equals the bit, and index 31, where it is always 0.
- R6: A write to 0x0C0 replaces the miscellaneous word. Only bit 12 is stored, and the others read 0. `uart_a_div13` equals that bit.
- R7: `uart_b_div13` equals bit 31 of clock-stop word 0x080. It is changed through the same set and clear addresses.
- R8: A read accepted at one clock edge gives `rsp_valid`=1 and the word in `rsp_rdata` after that edge. A read of base+4 returns the same value as its base. With no read accepted, `rsp_valid` is 0 after the edge.
- R9: Any other offset, including an offset not a multiple of 4, reads 0 and ignores writes.
- R10: `req_ready` is always 1. The outputs keep their values until the clock edge that accepts a write, and change right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| periph_rst | output | 64 | Per-peripheral reset, 1 = held |
| periph_clk_en | output | 64 | Per-peripheral clock enable, 1 = running |
| uart_a_div13 | output | 1 | First UART group uses the divide-by-13 reference |
| uart_b_div13 | output | 1 | Second UART group uses the divide-by-13 reference |

## Verification
The main function is exercised with sparse clear masks, multi-bit set masks and all-zero masks.

- Sparse clear masks show that only the named bits move.
- Set masks that overlap bits already at 1 show that set is an OR and not a load.
- All-zero masks show that untouched bits survive.
- Masks aimed at the upper words, including bits 0 and 31, separate the index-to-word mapping from a wrong shift.
- Clock writes that touch bits 14 and 31 separate the inverted-polarity gate and the divider-select bit from the ordinary gates.
- Writes and reads to clear aliases, to gaps between words and to offsets that are not word aligned show that the decode ignores what it must.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NUM_WORDS = 4;          // rst lo/hi, stop lo/hi
  localparam int LINES = 2 * DATA_W;     // peripherals per bank

  localparam logic [ADDR_W-1:0] OFS_RST_LO  = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_RST_HI  = 12'h050;
  localparam logic [ADDR_W-1:0] OFS_STOP_LO = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_STOP_HI = 12'h090;
  localparam logic [ADDR_W-1:0] OFS_MISC    = 12'h0C0;
  localparam int MISC_DIV_BIT = 12;

  typedef enum logic [2:0] {
    SEL_RST_LO  = 3'd0,
    SEL_RST_HI  = 3'd1,
    SEL_STOP_LO = 3'd2,
    SEL_STOP_HI = 3'd3,
    SEL_MISC    = 3'd4,
    SEL_NONE    = 3'd7
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e sel;
    logic     clr;
  } dec_t;

  // Offset -> register select; bit 2 picks the clear alias for the four
  // set/clear words. Misaligned offsets map nowhere.
  function automatic dec_t decode(logic [ADDR_W-1:0] a);
    dec_t d;
    logic [ADDR_W-1:0] base;
    d.sel = SEL_NONE;
    d.clr = 1'b0;
    base = {a[ADDR_W-1:3], 3'b000};
    if (a[1:0] == 2'b00) begin
      if (a == OFS_MISC) begin
        d.sel = SEL_MISC;
      end else begin
        case (base)
          OFS_RST_LO:  d.sel = SEL_RST_LO;
          OFS_RST_HI:  d.sel = SEL_RST_HI;
          OFS_STOP_LO: d.sel = SEL_STOP_LO;
          OFS_STOP_HI: d.sel = SEL_STOP_HI;
          default:     d.sel = SEL_NONE;
        endcase
        d.clr = a[2];
      end
    end
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] set_clr(logic [DATA_W-1:0] old,
                                                logic [DATA_W-1:0] mask,
                                                logic clr);
    return clr ? (old & ~mask) : (old | mask);
  endfunction

  // A gate runs when its stored bit differs from its stop sense.
  function automatic logic [LINES-1:0] clk_enable(logic [LINES-1:0] stop,
                                                  logic [LINES-1:0] inv,
                                                  logic [LINES-1:0] present);
    return present & ~(stop ^ inv);
  endfunction

endpackage

// File: rtl/scr_sc_word.sv
module scr_sc_word
  import scr_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clr,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else if (wr_en) q <= set_clr(q, mask, clr);
  end

endmodule

// File: rtl/scr_misc_reg.sv
module scr_misc_reg
  import scr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic div_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_sel <= 1'b0;
    else if (wr_en) div_sel <= wdata[MISC_DIV_BIT];
  end

  always_comb begin
    q = '0;
    q[MISC_DIV_BIT] = div_sel;
  end

endmodule

// File: rtl/scr_rd_port.sv
module scr_rd_port
  import scr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  reg_sel_e                    sel,
  input  logic [NUM_WORDS*DATA_W-1:0] words,
  input  logic [DATA_W-1:0]           misc,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_rdata
);

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    case (sel)
      SEL_RST_LO:  rd_mux = words[0*DATA_W +: DATA_W];
      SEL_RST_HI:  rd_mux = words[1*DATA_W +: DATA_W];
      SEL_STOP_LO: rd_mux = words[2*DATA_W +: DATA_W];
      SEL_STOP_HI: rd_mux = words[3*DATA_W +: DATA_W];
      SEL_MISC:    rd_mux = misc;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/scr_clkrst_regs.sv
module scr_clkrst_regs
  import scr_pkg::*;
#(
  parameter logic [LINES-1:0]  CLK_INV_POL  = 64'h0000_0000_0000_4000,
  parameter logic [LINES-1:0]  GATE_PRESENT = 64'hFFFF_FFFF_7FFF_FFFF,
  parameter logic [DATA_W-1:0] STOP_LO_RST  = 32'h7FFF_BFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [LINES-1:0]  periph_rst,
  output logic [LINES-1:0]  periph_clk_en,
  output logic              uart_a_div13,
  output logic              uart_b_div13
);

  localparam int STOP_LO_IDX = 2;
  localparam int UARTB_BIT   = DATA_W - 1;

  // named internal events
  logic     acc_wr;
  logic     acc_rd;
  dec_t     dec;
  logic [NUM_WORDS*DATA_W-1:0] words_flat;
  logic [DATA_W-1:0] misc_q;

  assign req_ready = 1'b1;
  assign acc_wr    = req_valid & req_ready & req_write;
  assign acc_rd    = req_valid & req_ready & ~req_write;
  assign dec       = decode(req_addr);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [DATA_W-1:0] RV = (w == STOP_LO_IDX) ? STOP_LO_RST : '1;
    logic hit;
    assign hit = acc_wr && (dec.sel == reg_sel_e'(w));
    scr_sc_word #(.RST_VAL(RV)) u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (hit),
      .clr   (dec.clr),
      .mask  (req_wdata),
      .q     (words_flat[w*DATA_W +: DATA_W])
    );
  end

  scr_misc_reg u_misc (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (acc_wr && dec.sel == SEL_MISC),
    .wdata (req_wdata),
    .q     (misc_q)
  );

  scr_rd_port u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (acc_rd),
    .sel       (dec.sel),
    .words     (words_flat),
    .misc      (misc_q),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign periph_rst    = words_flat[0 +: LINES];
  assign periph_clk_en = clk_enable(words_flat[LINES +: LINES], CLK_INV_POL, GATE_PRESENT);
  assign uart_a_div13  = misc_q[MISC_DIV_BIT];
  assign uart_b_div13  = words_flat[STOP_LO_IDX*DATA_W + UARTB_BIT];

endmodule

// File: rtl/scr_clkrst_regs_chk.sv
module scr_clkrst_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [11:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic [63:0] periph_rst,
  input logic [63:0] periph_clk_en,
  input logic        uart_a_div13,
  input logic        uart_b_div13
);

  logic wr_acc, rd_acc, mapped;
  assign wr_acc = req_valid && req_ready && req_write;
  assign rd_acc = req_valid && req_ready && !req_write;
  assign mapped = (req_addr == 12'h040) || (req_addr == 12'h044) ||
                  (req_addr == 12'h050) || (req_addr == 12'h054) ||
                  (req_addr == 12'h080) || (req_addr == 12'h084) ||
                  (req_addr == 12'h090) || (req_addr == 12'h094) ||
                  (req_addr == 12'h0C0);

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n) req_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_acc |=> $stable(periph_rst) && $stable(periph_clk_en) &&
                $stable(uart_a_div13) && $stable(uart_b_div13));

  p_set_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == 12'h040) |=>
      ((periph_rst[31:0] & $past(req_wdata)) == $past(req_wdata)));

  p_clr_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == 12'h054) |=>
      ((periph_rst[63:32] & $past(req_wdata)) == 32'h0));

  p_gate31_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_clk_en[31]);

  p_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  p_norsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rsp_valid);

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !mapped) |=> $stable(periph_rst) && $stable(periph_clk_en) &&
                            $stable(uart_a_div13) && $stable(uart_b_div13));

endmodule

bind scr_clkrst_regs scr_clkrst_regs_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .req_wdata     (req_wdata),
  .rsp_valid     (rsp_valid),
  .periph_rst    (periph_rst),
  .periph_clk_en (periph_clk_en),
  .uart_a_div13  (uart_a_div13),
  .uart_b_div13  (uart_b_div13)
);

// File: tb/scr_clkrst_regs_tb_top.sv
module scr_clkrst_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [63:0] periph_rst;
  logic [63:0] periph_clk_en;
  logic        uart_a_div13;
  logic        uart_b_div13;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model of stored state
  logic [63:0] m_rst;
  logic [63:0] m_stop;
  logic        m_misc;

  always #10 clk = ~clk;   // 50 MHz

  scr_clkrst_regs dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .periph_rst(periph_rst),
    .periph_clk_en(periph_clk_en), .uart_a_div13(uart_a_div13),
    .uart_b_div13(uart_b_div13)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected enables: stop bit inverted, bit 14 direct, bit 31 never
  function automatic logic [63:0] exp_en(logic [63:0] stop);
    logic [63:0] e;
    for (int i = 0; i < 64; i++) begin
      if (i == 31) e[i] = 1'b0;
      else if (i == 14) e[i] = stop[i];
      else e[i] = !stop[i];
    end
    return e;
  endfunction

  task automatic check_outs(string req);
    check(req, periph_rst, m_rst);
    check(req, periph_clk_en, exp_en(m_stop));
    check(req, {62'd0, uart_a_div13, uart_b_div13}, {62'd0, m_misc, m_stop[31]});
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  task automatic rd_check(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    logic v;
    rd(a, d, v);
    check(req, {32'd0, d}, {32'd0, exp});
    check(req, {63'd0, v}, 64'd1);
  endtask

  task automatic t_reset();
    check_outs("R1 reset outputs");
    check("R1 clk_en zero", periph_clk_en, 64'd0);
    check("R10 ready", {63'd0, req_ready}, 64'd1);
    rd_check("R1 stop lo", 12'h080, 32'h7FFF_BFFF);
    rd_check("R1 stop hi", 12'h090, 32'hFFFF_FFFF);
    rd_check("R1 rst lo", 12'h040, 32'hFFFF_FFFF);
    rd_check("R1 misc", 12'h0C0, 32'h0);
    @(negedge clk);
    check("R8 no read no rsp", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_rst_words();
    wr(12'h044, 32'h0000_00F0); m_rst[31:0] &= ~32'h0000_00F0;
    check_outs("R3 clear lo");
    wr(12'h054, 32'h8000_0001); m_rst[63:32] &= ~32'h8000_0001;
    check_outs("R4 clear hi edges");
    wr(12'h040, 32'h0000_0011); m_rst[31:0] |= 32'h0000_0011;
    check_outs("R2 set overlapping");
    wr(12'h040, 32'h0);
    check_outs("R2 zero mask");
    wr(12'h050, 32'h0000_0001); m_rst[63:32] |= 32'h1;
    check_outs("R4 set index 32");
    rd_check("R4 rst hi readback", 12'h050, m_rst[63:32]);
  endtask

  task automatic t_clk_words();
    wr(12'h084, 32'h0000_0003); m_stop[31:0] &= ~32'h3;
    check_outs("R5 run gates 0,1");
    wr(12'h080, 32'h0000_4000); m_stop[31:0] |= 32'h4000;
    check_outs("R5 bit 14 set runs");
    check("R5 bit14 on", {63'd0, periph_clk_en[14]}, 64'd1);
    wr(12'h094, 32'h8000_0001); m_stop[63:32] &= ~32'h8000_0001;
    check_outs("R5 upper gates 32,63");
    wr(12'h084, 32'h0000_4000); m_stop[31:0] &= ~32'h4000;
    check_outs("R5 bit 14 clear stops");
  endtask

  task automatic t_uart();
    wr(12'h0C0, 32'h0000_1000); m_misc = 1'b1;
    check_outs("R6 div13 a on");
    rd_check("R6 misc read", 12'h0C0, 32'h0000_1000);
    wr(12'h0C0, 32'hFFFF_EFFF); m_misc = 1'b0;
    check_outs("R6 div13 a off by replace");
    rd_check("R6 only bit 12 kept", 12'h0C0, 32'h0);
    wr(12'h080, 32'h8000_0000); m_stop[31] = 1'b1;
    check_outs("R7 div13 b on");
    check("R7 gate 31 not enabled", {63'd0, periph_clk_en[31]}, 64'd0);
    wr(12'h084, 32'h8000_0000); m_stop[31] = 1'b0;
    check_outs("R7 div13 b off");
  endtask

  task automatic t_alias();
    rd_check("R8 alias rst lo", 12'h044, m_rst[31:0]);
    rd_check("R8 alias stop lo", 12'h084, m_stop[31:0]);
    rd_check("R8 alias stop hi", 12'h094, m_stop[63:32]);
  endtask

  task automatic t_unmapped();
    wr(12'h048, 32'hFFFF_FFFF);
    wr(12'h046, 32'hFFFF_FFFF);
    wr(12'h0C4, 32'hFFFF_FFFF);
    wr(12'h042, 32'hFFFF_FFFF);
    check_outs("R9 unmapped writes ignored");
    rd_check("R9 gap reads zero", 12'h048, 32'h0);
    rd_check("R9 misaligned reads zero", 12'h041, 32'h0);
    rd_check("R9 misc alias zero", 12'h0C4, 32'h0);
  endtask

  task automatic t_timing();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h044; req_wdata = 32'h0000_0100;
    #5;
    check_outs("R10 no change before edge");
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    m_rst[8] = 1'b0;
    check_outs("R10 change after edge");
  endtask

  initial begin
    m_rst = '1;
    m_stop = {32'hFFFF_FFFF, 32'h7FFF_BFFF};
    m_misc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rst_words();
    t_clk_words();
    t_uart();
    t_alias();
    t_unmapped();
    t_timing();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule